// File: doc/BRIEF.md
# Counter Delta Accumulator

The block tracks a set of free-running 48-bit event counters and turns their successive snapshots into accumulated event counts. Each tracked entry holds the last raw reading it saw, a scaling factor, a normalise flag and a 64-bit accumulator. Every update takes the difference between the current reading and the stored one, modulo 2^48 so a counter that wrapped still yields the right count. It multiplies that difference by the entry's scale, divides it by the current clock frequency when the entry asks for normalisation, and adds the result to the accumulator.

The current readings of all counters arrive in parallel on `snap_raw`, with one valid bit per counter. A cleared valid bit means no fresh reading exists, for example while the counter domain is powered down. A query runs an update, returns the accumulator and clears it. A frequency-change command sweeps every active normalised entry, updating it at the old frequency, and only then latches the new one. Division uses a bit-serial restoring divider, so normalised updates take many more cycles than plain ones. `busy` is high while a command is in progress, and commands offered during that time are dropped.

The controller has five states. IDLE accepts commands. SCAN looks for the next normalised entry during a sweep. CALC forms the delta and the product and writes back the raw value. DIV waits for the divider. ACC adds to the accumulator and answers queries.

The transitions are:
- IDLE→CALC on an update or query.
- IDLE→SCAN on a frequency change.
- SCAN→CALC when an entry is hit.
- SCAN→IDLE after the last entry.
- CALC→DIV when normalising at a nonzero frequency.
- CALC→ACC otherwise.
- DIV→ACC on divider completion.
- ACC→SCAN while a sweep has entries left.
- ACC→IDLE otherwise.

Top module: `ctr_delta_accum`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `freq_zero_warn` are 0 and the current frequency is 0.
- R2: `cmd_op` encodes 0 = start, 1 = update, 2 = query, 3 = frequency change. A start on entry `cmd_idx` loads the entry's stored reading from its `snap_raw` slot (bits idx*48 upward), and loads scale and normalise flag from `cmd_scale` and `cmd_norm`. It clears the accumulator, completes in the accepting cycle without raising `busy`, and accumulates no delta.
- R3: An update or query adds (new − stored) × scale to the accumulator and replaces the stored reading with the new one.
- R4: When the new reading is below the stored one, the delta is new + 2^48 − stored.
- R5: When the entry's `snap_vld` bit is 0, the stored reading is reused: the delta is zero and the stored value is kept for later updates.
- R6: Deltas from successive updates add up. A query returns the sum, including its own delta, on `rsp_value` with `rsp_idx`, during a one-cycle `rsp_valid` pulse, and then leaves the accumulator at zero.
- R7: For an entry with the normalise flag set and a nonzero current frequency, the scaled delta is divided by the frequency, truncated, before it is accumulated.
- R8: For a normalised entry at frequency zero, the division is skipped, and `freq_zero_warn` becomes 1 and stays 1 until reset.
- R9: A frequency change first updates every started, normalised entry at the old frequency, then latches `cmd_freq` as the current frequency. Non-normalised entries are left untouched.
- R10: While `busy` is 1, commands are ignored.
- R11: `rsp_valid` rises 2 clock edges after the edge that accepts a query on the plain path, and 67 edges after it on the divide path. `busy` is 1 in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | Command code (see R2) |
| cmd_idx | input | IDX_W (3) | Entry selected by the command |
| cmd_scale | input | SCALE_W (16) | Scaling factor loaded on start |
| cmd_norm | input | 1 | Normalise flag loaded on start |
| cmd_freq | input | FREQ_W (32) | New frequency for a frequency change |
| snap_raw | input | NUM_CTR*RAW_W (384) | Current readings, entry i at bits i*48 upward |
| snap_vld | input | NUM_CTR (8) | Per-entry fresh-reading valid bits |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | Query result valid, one cycle |
| rsp_idx | output | IDX_W (3) | Entry the result belongs to |
| rsp_value | output | ACC_W (64) | Accumulated value returned by a query |
| freq_zero_warn | output | 1 | Sticky: normalisation hit a zero frequency |

## Verification
A query that needs no division registers its product in CALC and its response in ACC, so `rsp_valid` is due two edges after the accepting edge. When the divider runs, the 64 quotient steps plus the start and completion hand-offs put the response at edge 67. The bench drives commands on falling edges and counts falling edges from the accepting edge until `rsp_valid` appears. It checks both the value and that exact count. Updates and sweeps are followed by a wait for `busy` to drop before the next command, and the dropped-command case is driven on the falling edge immediately after acceptance, when `busy` is already high.

// File: rtl/ctr_delta_pkg.sv
package ctr_delta_pkg;

    typedef enum logic [1:0] {
        OP_START  = 2'd0,
        OP_UPDATE = 2'd1,
        OP_QUERY  = 2'd2,
        OP_FREQ   = 2'd3
    } ctr_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CALC,
        ST_DIV,
        ST_ACC
    } ctr_state_e;

endpackage

// File: rtl/ctr_wrap_scale.sv
// Modular delta between two counter readings, widened and scaled.
module ctr_wrap_scale #(
    parameter int RAW_W   = 48,
    parameter int SCALE_W = 16,
    localparam int PROD_W = RAW_W + SCALE_W
) (
    input  logic [RAW_W-1:0]   cur_raw,
    input  logic [RAW_W-1:0]   prev_raw,
    input  logic [SCALE_W-1:0] scale,
    output logic [PROD_W-1:0]  product
);

    logic [RAW_W-1:0] delta;

    // Subtraction in RAW_W bits is exactly the wrap-aware distance.
    always_comb begin
        delta   = cur_raw - prev_raw;
        product = PROD_W'(delta) * PROD_W'(scale);
    end

endmodule

// File: rtl/ctr_seq_div.sv
// Restoring divider producing one quotient bit per cycle.
module ctr_seq_div #(
    parameter int N_W = 64,
    parameter int D_W = 32,
    localparam int CNT_W = $clog2(N_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic           done,
    output logic [N_W-1:0] quotient
);

    logic [D_W-1:0]   rem_q;
    logic [N_W-1:0]   quo_q;
    logic [D_W-1:0]   div_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             done_q;

    logic [D_W:0]     shifted;
    logic [D_W:0]     trial;
    logic             step_bit;
    logic [D_W-1:0]   step_rem;

    always_comb begin
        shifted  = {rem_q, quo_q[N_W-1]};
        trial    = shifted - {1'b0, div_q};
        step_bit = ~trial[D_W];
        step_rem = step_bit ? trial[D_W-1:0] : shifted[D_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q <= '0;
                quo_q <= dividend;
                div_q <= divisor;
                cnt_q <= CNT_W'(N_W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= step_rem;
                quo_q <= {quo_q[N_W-2:0], step_bit};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CNT_W'(1)) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done     = done_q;
    assign quotient = quo_q;

endmodule

// File: rtl/ctr_entry_file.sv
// Per-entry state: stored reading, scale, normalise flag, accumulator.
module ctr_entry_file #(
    parameter int NUM_CTR = 8,
    parameter int RAW_W   = 48,
    parameter int SCALE_W = 16,
    parameter int ACC_W   = 64,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_we,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [RAW_W-1:0]   ld_raw,
    input  logic [SCALE_W-1:0] ld_scale,
    input  logic               ld_norm,
    input  logic               raw_we,
    input  logic [RAW_W-1:0]   raw_val,
    input  logic               acc_we,
    input  logic [ACC_W-1:0]   acc_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [RAW_W-1:0]   rd_last,
    output logic [SCALE_W-1:0] rd_scale,
    output logic               rd_norm,
    output logic [ACC_W-1:0]   rd_acc,
    output logic [NUM_CTR-1:0] norm_vec,
    output logic [NUM_CTR-1:0] active_vec
);

    logic [RAW_W-1:0]   last_arr  [NUM_CTR];
    logic [SCALE_W-1:0] scale_arr [NUM_CTR];
    logic [ACC_W-1:0]   acc_arr   [NUM_CTR];

    for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_entry
        logic [RAW_W-1:0]   last_r;
        logic [SCALE_W-1:0] scale_r;
        logic [ACC_W-1:0]   acc_r;
        logic               norm_r;
        logic               act_r;
        logic               ld_hit;
        logic               upd_hit;

        assign ld_hit  = ld_we && (ld_idx == IDX_W'(gi));
        assign upd_hit = rd_idx == IDX_W'(gi);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                last_r  <= '0;
                scale_r <= '0;
                acc_r   <= '0;
                norm_r  <= 1'b0;
                act_r   <= 1'b0;
            end else if (ld_hit) begin
                last_r  <= ld_raw;
                scale_r <= ld_scale;
                norm_r  <= ld_norm;
                acc_r   <= '0;
                act_r   <= 1'b1;
            end else begin
                if (raw_we && upd_hit) last_r <= raw_val;
                if (acc_we && upd_hit) acc_r  <= acc_val;
            end
        end

        assign last_arr[gi]   = last_r;
        assign scale_arr[gi]  = scale_r;
        assign acc_arr[gi]    = acc_r;
        assign norm_vec[gi]   = norm_r;
        assign active_vec[gi] = act_r;
    end

    assign rd_last  = last_arr[rd_idx];
    assign rd_scale = scale_arr[rd_idx];
    assign rd_acc   = acc_arr[rd_idx];
    assign rd_norm  = norm_vec[rd_idx];

endmodule

// File: rtl/ctr_delta_accum.sv
module ctr_delta_accum
    import ctr_delta_pkg::*;
#(
    parameter int NUM_CTR = 8,
    parameter int RAW_W   = 48,
    parameter int SCALE_W = 16,
    parameter int ACC_W   = 64,
    parameter int FREQ_W  = 32,
    localparam int IDX_W  = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1,
    localparam int PROD_W = RAW_W + SCALE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [1:0]                 cmd_op,
    input  logic [IDX_W-1:0]           cmd_idx,
    input  logic [SCALE_W-1:0]         cmd_scale,
    input  logic                       cmd_norm,
    input  logic [FREQ_W-1:0]          cmd_freq,
    input  logic [NUM_CTR*RAW_W-1:0]   snap_raw,
    input  logic [NUM_CTR-1:0]         snap_vld,
    output logic                       busy,
    output logic                       rsp_valid,
    output logic [IDX_W-1:0]           rsp_idx,
    output logic [ACC_W-1:0]           rsp_value,
    output logic                       freq_zero_warn
);

    ctr_state_e state_q, state_d;
    ctr_op_e    op_in;

    logic [IDX_W-1:0]  idx_q;
    logic              query_q;
    logic              sweep_q;
    logic [FREQ_W-1:0] freq_q;
    logic [FREQ_W-1:0] freq_pend_q;
    logic [ACC_W-1:0]  addend_q;
    logic              warn_q;
    logic              rsp_valid_q;
    logic [IDX_W-1:0]  rsp_idx_q;
    logic [ACC_W-1:0]  rsp_value_q;

    logic [RAW_W-1:0]   rd_last;
    logic [SCALE_W-1:0] rd_scale;
    logic               rd_norm;
    logic [ACC_W-1:0]   rd_acc;
    logic [NUM_CTR-1:0] norm_vec;
    logic [NUM_CTR-1:0] active_vec;

    logic [RAW_W-1:0]  cur_raw;
    logic [PROD_W-1:0] product;
    logic [PROD_W-1:0] quotient;
    logic              div_done;
    logic              div_start;
    logic              accept;
    logic              last_idx;
    logic              scan_hit;
    logic              need_div;
    logic [ACC_W-1:0]  acc_sum;

    assign op_in    = ctr_op_e'(cmd_op);
    assign accept   = (state_q == ST_IDLE) && cmd_valid;
    assign last_idx = idx_q == IDX_W'(NUM_CTR - 1);
    assign scan_hit = norm_vec[idx_q] && active_vec[idx_q];
    assign need_div = rd_norm && (freq_q != '0);
    assign cur_raw  = snap_vld[idx_q] ? snap_raw[idx_q*RAW_W +: RAW_W] : rd_last;
    assign acc_sum  = rd_acc + addend_q;
    assign div_start = (state_q == ST_CALC) && need_div;

    ctr_entry_file #(
        .NUM_CTR (NUM_CTR),
        .RAW_W   (RAW_W),
        .SCALE_W (SCALE_W),
        .ACC_W   (ACC_W)
    ) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (accept && (op_in == OP_START)),
        .ld_idx     (cmd_idx),
        .ld_raw     (snap_raw[cmd_idx*RAW_W +: RAW_W]),
        .ld_scale   (cmd_scale),
        .ld_norm    (cmd_norm),
        .raw_we     (state_q == ST_CALC),
        .raw_val    (cur_raw),
        .acc_we     (state_q == ST_ACC),
        .acc_val    (query_q ? '0 : acc_sum),
        .rd_idx     (idx_q),
        .rd_last    (rd_last),
        .rd_scale   (rd_scale),
        .rd_norm    (rd_norm),
        .rd_acc     (rd_acc),
        .norm_vec   (norm_vec),
        .active_vec (active_vec)
    );

    ctr_wrap_scale #(
        .RAW_W   (RAW_W),
        .SCALE_W (SCALE_W)
    ) u_scale (
        .cur_raw  (cur_raw),
        .prev_raw (rd_last),
        .scale    (rd_scale),
        .product  (product)
    );

    ctr_seq_div #(
        .N_W (PROD_W),
        .D_W (FREQ_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (product),
        .divisor  (freq_q),
        .done     (div_done),
        .quotient (quotient)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (op_in)
                        OP_UPDATE, OP_QUERY: state_d = ST_CALC;
                        OP_FREQ:             state_d = ST_SCAN;
                        OP_START:            state_d = ST_IDLE;
                    endcase
                end
            end
            ST_SCAN: begin
                if (scan_hit)      state_d = ST_CALC;
                else if (last_idx) state_d = ST_IDLE;
            end
            ST_CALC: state_d = need_div ? ST_DIV : ST_ACC;
            ST_DIV:  if (div_done) state_d = ST_ACC;
            ST_ACC:  state_d = (sweep_q && !last_idx) ? ST_SCAN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            query_q     <= 1'b0;
            sweep_q     <= 1'b0;
            freq_q      <= '0;
            freq_pend_q <= '0;
            addend_q    <= '0;
            warn_q      <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_idx_q   <= '0;
            rsp_value_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        query_q <= (op_in == OP_QUERY);
                        sweep_q <= (op_in == OP_FREQ);
                        if (op_in == OP_FREQ) begin
                            idx_q       <= '0;
                            freq_pend_q <= cmd_freq;
                        end else begin
                            idx_q <= cmd_idx;
                        end
                    end
                end
                ST_SCAN: begin
                    if (!scan_hit) begin
                        if (last_idx) begin
                            freq_q  <= freq_pend_q;
                            sweep_q <= 1'b0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_CALC: begin
                    addend_q <= ACC_W'(product);
                    if (rd_norm && (freq_q == '0)) warn_q <= 1'b1;
                end
                ST_DIV: begin
                    if (div_done) addend_q <= ACC_W'(quotient);
                end
                ST_ACC: begin
                    if (query_q) begin
                        rsp_valid_q <= 1'b1;
                        rsp_idx_q   <= idx_q;
                        rsp_value_q <= acc_sum;
                    end
                    if (sweep_q) begin
                        if (last_idx) begin
                            freq_q  <= freq_pend_q;
                            sweep_q <= 1'b0;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy           = state_q != ST_IDLE;
    assign rsp_valid      = rsp_valid_q;
    assign rsp_idx        = rsp_idx_q;
    assign rsp_value      = rsp_value_q;
    assign freq_zero_warn = warn_q;

endmodule

// File: rtl/ctr_delta_accum_chk.sv
module ctr_delta_accum_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_op,
    input logic       busy,
    input logic       rsp_valid,
    input logic       freq_zero_warn
);

    // R2: a start completes without occupying the block
    p_start_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd0) |=> !busy);

    // R10: any other accepted command occupies the block next cycle
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op != 2'd0) |=> busy);

    // R6: query response is a single-cycle pulse
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11: the response coincides with the return to idle
    p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R8: the zero-frequency warning is sticky
    p_warn_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freq_zero_warn |=> freq_zero_warn);

endmodule

bind ctr_delta_accum ctr_delta_accum_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .busy           (busy),
    .rsp_valid      (rsp_valid),
    .freq_zero_warn (freq_zero_warn)
);

// File: tb/ctr_delta_accum_tb.sv
module ctr_delta_accum_tb;

    localparam int CLK_P   = 10;
    localparam int NUM_CTR = 8;
    localparam int RAW_W   = 48;
    localparam int LAT_PLAIN = 2;
    localparam int LAT_DIV   = 67;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     cmd_valid = 1'b0;
    logic [1:0]               cmd_op = '0;
    logic [2:0]               cmd_idx = '0;
    logic [15:0]              cmd_scale = '0;
    logic                     cmd_norm = 1'b0;
    logic [31:0]              cmd_freq = '0;
    logic [NUM_CTR*RAW_W-1:0] snap_raw = '0;
    logic [NUM_CTR-1:0]       snap_vld = '1;
    logic                     busy;
    logic                     rsp_valid;
    logic [2:0]               rsp_idx;
    logic [63:0]              rsp_value;
    logic                     freq_zero_warn;

    int checks = 0;
    int failures = 0;

    always #(CLK_P/2) clk = ~clk;

    ctr_delta_accum u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_valid      (cmd_valid),
        .cmd_op         (cmd_op),
        .cmd_idx        (cmd_idx),
        .cmd_scale      (cmd_scale),
        .cmd_norm       (cmd_norm),
        .cmd_freq       (cmd_freq),
        .snap_raw       (snap_raw),
        .snap_vld       (snap_vld),
        .busy           (busy),
        .rsp_valid      (rsp_valid),
        .rsp_idx        (rsp_idx),
        .rsp_value      (rsp_value),
        .freq_zero_warn (freq_zero_warn)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_raw(input int idx, input logic [47:0] val, input bit vld);
        snap_raw[idx*RAW_W +: RAW_W] = val;
        snap_vld[idx] = vld;
    endtask

    // Drives one command for one clock edge; returns on the following falling edge.
    task automatic issue(input logic [1:0] op, input int idx, input logic [15:0] sc,
                         input bit nm, input logic [31:0] fq);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_idx   = 3'(idx);
        cmd_scale = sc;
        cmd_norm  = nm;
        cmd_freq  = fq;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    endtask

    task automatic wait_rsp(input int n0, output int lat);
        lat = n0;
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic query_chk(input int idx, input logic [63:0] exp, input int exp_lat,
                             input string req);
        int lat;
        issue(2'd2, idx, '0, 1'b0, '0);
        wait_rsp(0, lat);
        check(rsp_valid && rsp_value == exp, req, "query value", rsp_value, exp);
        check(lat == exp_lat, "R11", "response latency", 64'(lat), 64'(exp_lat));
        check(rsp_idx == 3'(idx), req, "response index", 64'(rsp_idx), 64'(idx));
        @(negedge clk);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1", "busy after reset", 64'(busy), 0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
        check(freq_zero_warn == 1'b0, "R1", "warn after reset", 64'(freq_zero_warn), 0);
    endtask

    task automatic t_start_basic();
        set_raw(0, 48'd1000, 1'b1);
        issue(2'd0, 0, 16'd3, 1'b0, '0);
        check(busy == 1'b0, "R2", "start leaves block idle", 64'(busy), 0);
        query_chk(0, 64'd0, LAT_PLAIN, "R2");
        set_raw(0, 48'd1500, 1'b1);
        query_chk(0, 64'd1500, LAT_PLAIN, "R3");
        query_chk(0, 64'd0, LAT_PLAIN, "R6");
    endtask

    task automatic t_accum();
        set_raw(1, 48'd10, 1'b1);
        issue(2'd0, 1, 16'd2, 1'b0, '0);
        set_raw(1, 48'd20, 1'b1);
        issue(2'd1, 1, '0, 1'b0, '0);
        wait_idle();
        set_raw(1, 48'd50, 1'b1);
        issue(2'd1, 1, '0, 1'b0, '0);
        wait_idle();
        set_raw(1, 48'd51, 1'b1);
        query_chk(1, 64'd82, LAT_PLAIN, "R6");
    endtask

    task automatic t_wrap();
        logic [47:0] top_val;
        top_val = 48'hFFFF_FFFF_FFFB;
        set_raw(2, top_val, 1'b1);
        issue(2'd0, 2, 16'd1, 1'b0, '0);
        set_raw(2, 48'd10, 1'b1);
        query_chk(2, 64'd15, LAT_PLAIN, "R4");
    endtask

    task automatic t_noread();
        set_raw(3, 48'd100, 1'b1);
        issue(2'd0, 3, 16'd5, 1'b0, '0);
        set_raw(3, 48'd400, 1'b0);
        issue(2'd1, 3, '0, 1'b0, '0);
        wait_idle();
        query_chk(3, 64'd0, LAT_PLAIN, "R5");
        set_raw(3, 48'd400, 1'b1);
        query_chk(3, 64'd1500, LAT_PLAIN, "R5");
    endtask

    task automatic t_freq_zero();
        set_raw(4, 48'd0, 1'b1);
        issue(2'd0, 4, 16'd1, 1'b1, '0);
        check(freq_zero_warn == 1'b0, "R8", "warn before zero-freq use", 64'(freq_zero_warn), 0);
        set_raw(4, 48'd777, 1'b1);
        query_chk(4, 64'd777, LAT_PLAIN, "R8");
        check(freq_zero_warn == 1'b1, "R8", "warn after zero-freq use", 64'(freq_zero_warn), 1);
    endtask

    task automatic t_freq_change();
        set_raw(4, 48'd5777, 1'b1);
        set_raw(0, 48'd2500, 1'b1);
        issue(2'd3, 0, '0, 1'b0, 32'd1000);
        wait_idle();
        query_chk(4, 64'd5000, LAT_DIV, "R9");
        query_chk(0, 64'd3000, LAT_PLAIN, "R9");
        check(freq_zero_warn == 1'b1, "R8", "warn stays set", 64'(freq_zero_warn), 1);
    endtask

    task automatic t_norm();
        logic [63:0] big;
        set_raw(5, 48'd0, 1'b1);
        issue(2'd0, 5, 16'd7, 1'b1, '0);
        set_raw(5, 48'd123456, 1'b1);
        query_chk(5, 64'd864, LAT_DIV, "R7");
        set_raw(6, 48'd0, 1'b1);
        issue(2'd0, 6, 16'hFFFF, 1'b1, '0);
        set_raw(6, 48'hFFFF_FFFF_FFFF, 1'b1);
        big = (64'h0000_FFFF_FFFF_FFFF * 64'd65535) / 64'd1000;
        query_chk(6, big, LAT_DIV, "R7");
    endtask

    task automatic t_busy_ignore();
        int lat;
        set_raw(1, 48'd61, 1'b1);
        issue(2'd2, 1, '0, 1'b0, '0);
        check(busy == 1'b1, "R10", "busy during query", 64'(busy), 1);
        cmd_valid = 1'b1;
        cmd_op    = 2'd0;
        cmd_idx   = 3'd1;
        cmd_scale = 16'd9;
        cmd_norm  = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_rsp(1, lat);
        check(rsp_valid && rsp_value == 64'd20, "R10", "query value", rsp_value, 64'd20);
        @(negedge clk);
        set_raw(1, 48'd71, 1'b1);
        query_chk(1, 64'd20, LAT_PLAIN, "R10");
    endtask

    initial begin
        #(CLK_P * 150000);
        failures++;
        $display("FAIL watchdog R11 actual=hung expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_start_basic();
        t_accum();
        t_wrap();
        t_noread();
        t_freq_zero();
        t_freq_change();
        t_norm();
        t_busy_ignore();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule